// File: doc/BRIEF.md
# BCD Stopwatch Time Counter

This block keeps elapsed time for a three-digit stopwatch. The time is held as binary-coded decimal in three digits: tenths of a second, units of seconds and tens of seconds. The block runs directly from a 10 Hz clock and has no internal divider. While the stopwatch is running, the tenths digit advances once per clock. Decimal carries ripple into the units-of-seconds digit and from there into the tens-of-seconds digit. The count wraps from 59.9 back to 00.0 and keeps running.

Two plain control inputs drive the stopwatch. A run/pause input flips the stopwatch between running and paused. A clear input zeroes the time and pauses the stopwatch. Each input acts only on its rising edge. The block finds these edges itself by comparing each input with a registered copy of its previous value, so holding an input high does nothing further. When a clear edge and a run/pause edge arrive in the same cycle, the clear edge wins.

A synchronous power-on reset puts the block in its idle state. Debouncing, clock generation and display decoding belong to other blocks.

Top module: `sw_bcd_timer`

## Requirements
- R1: While `rst_i` is high at a clock edge, all three digits become 0 and the stopwatch becomes paused; after reset no digit changes until a run/pause rising edge has been seen.
- R2: A rising edge on `run_tgl_i` (high now, low in the previous cycle) while paused sets the running state at that clock edge. The tenths digit first increments at the following edge and then increments by exactly one at every edge.
- R3: The tenths digit counts 0 to 9. A step from 9 wraps it to 0 and increments the units-of-seconds digit in the same edge.
- R4: The units-of-seconds digit counts 0 to 9 and changes only when the tenths digit wraps. Its own wrap from 9 to 0 increments the tens-of-seconds digit.
- R5: The tens-of-seconds digit counts 0 to 5. A step from 59.9 gives 00.0 and counting continues.
- R6: A rising edge on `run_tgl_i` while running pauses the stopwatch. The edge that detects it still applies one final increment. After that edge all digits hold their values.
- R7: Holding `run_tgl_i` or `clear_i` high for several cycles acts only once, in the cycle of the rising edge.
- R8: A rising edge on `clear_i` sets all three digits to 0 at that clock edge and leaves the stopwatch paused.
- R9: When rising edges on `clear_i` and `run_tgl_i` occur in the same cycle, the clear wins: the digits become 0 and the stopwatch stays paused.
- R10: A run/pause rising edge after a pause resumes counting from the held time, not from zero.
- R11: Each digit always holds a legal value: tenths and units at most 9, tens at most 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 10 Hz time-base clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous power-on reset, active high |
| run_tgl_i | input | 1 | Run/pause control; each rising edge flips the run state |
| clear_i | input | 1 | Clear control; a rising edge zeroes the time and pauses |
| sec_tens_o | output | 4 | BCD tens-of-seconds digit (0 to 5) |
| sec_ones_o | output | 4 | BCD units-of-seconds digit (0 to 9) |
| tenths_o | output | 4 | BCD tenths-of-a-second digit (0 to 9) |

## Verification
The bound checker watches on every cycle that each digit stays in its legal range and that every tenths change is a single step with a wrap at 9. It also checks that the units digit moves only on a tenths wrap, that the tenths wrap carries, and that 59.9 goes to 00.0. Clear edges, including a clear edge that coincides with a run/pause edge, must leave zeroes on the following cycles.

The run state is not visible at the ports, so the bench's scenarios cover the rest. These are the one-cycle delay between a run/pause edge and the first count, and the final increment on the pausing edge. They also include holding while paused, resuming from the held time, level-held controls acting only once, and a full sweep through every carry and the minute wrap.

// File: rtl/sw_pkg.sv
package sw_pkg;
  // Default digit width and per-digit ceilings of the time chain
  localparam int SW_DIGIT_W   = 4;
  localparam int SW_TENTHS_MAX = 9;
  localparam int SW_ONES_MAX   = 9;
  localparam int SW_TENS_MAX   = 5;
  // Digit order in the chain: index 0 ticks fastest
  localparam int SW_NDIG = 3;
endpackage

// File: rtl/sw_rise_detect.sv
module sw_rise_detect (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= lvl_i;
  end

  // One-cycle pulse when the level goes from low to high
  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sw_run_ctrl.sv
module sw_run_ctrl (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tgl_rise_i,
  input  logic clr_rise_i,
  output logic run_o
);
  logic run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)           run_q <= 1'b0;
    else if (clr_rise_i) run_q <= 1'b0;      // clear has priority (R9)
    else if (tgl_rise_i) run_q <= ~run_q;
  end

  assign run_o = run_q;
endmodule

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit #(
  parameter int W   = 4,
  parameter int MAX = 9
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic [W-1:0] q_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) q_q <= '0;
    else if (inc_i)     q_q <= (q_q == TOP) ? '0 : q_q + W'(1);
  end

  assign q_o = q_q;
endmodule

// File: rtl/sw_bcd_timer.sv
module sw_bcd_timer
  import sw_pkg::*;
#(
  parameter int DIGIT_W    = SW_DIGIT_W,
  parameter int TENTHS_MAX = SW_TENTHS_MAX,
  parameter int ONES_MAX   = SW_ONES_MAX,
  parameter int TENS_MAX   = SW_TENS_MAX
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               run_tgl_i,
  input  logic               clear_i,
  output logic [DIGIT_W-1:0] sec_tens_o,
  output logic [DIGIT_W-1:0] sec_ones_o,
  output logic [DIGIT_W-1:0] tenths_o
);
  localparam int NDIG = SW_NDIG;
  localparam int NCTL = 2;   // bit 0: run/pause, bit 1: clear

  logic [NCTL-1:0] ctl_lvl, ctl_rise;
  logic            run;
  logic [NDIG-1:0] inc;
  logic [NDIG-1:0][DIGIT_W-1:0] dig;

  assign ctl_lvl = {clear_i, run_tgl_i};

  for (genvar c = 0; c < NCTL; c++) begin : g_edge
    sw_rise_detect u_rise (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .lvl_i (ctl_lvl[c]),
      .rise_o(ctl_rise[c])
    );
  end

  sw_run_ctrl u_run (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tgl_rise_i(ctl_rise[0]),
    .clr_rise_i(ctl_rise[1]),
    .run_o     (run)
  );

  assign inc[0] = run;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    localparam int LIM = (g == 0) ? TENTHS_MAX : (g == 1) ? ONES_MAX : TENS_MAX;

    sw_bcd_digit #(.W(DIGIT_W), .MAX(LIM)) u_digit (
      .clk_i(clk_i),
      .rst_i(rst_i),
      .clr_i(ctl_rise[1]),
      .inc_i(inc[g]),
      .q_o  (dig[g])
    );

    if (g < NDIG - 1) begin : g_carry
      assign inc[g+1] = inc[g] && (dig[g] == DIGIT_W'(LIM));
    end
  end

  assign tenths_o   = dig[0];
  assign sec_ones_o = dig[1];
  assign sec_tens_o = dig[2];
endmodule

// File: rtl/sw_bcd_timer_chk.sv
module sw_bcd_timer_chk #(
  parameter int DIGIT_W    = 4,
  parameter int TENTHS_MAX = 9,
  parameter int ONES_MAX   = 9,
  parameter int TENS_MAX   = 5
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               run_tgl_i,
  input logic               clear_i,
  input logic [DIGIT_W-1:0] sec_tens_o,
  input logic [DIGIT_W-1:0] sec_ones_o,
  input logic [DIGIT_W-1:0] tenths_o
);
  localparam logic [DIGIT_W-1:0] T_TOP = DIGIT_W'(TENTHS_MAX);
  localparam logic [DIGIT_W-1:0] O_TOP = DIGIT_W'(ONES_MAX);
  localparam logic [DIGIT_W-1:0] S_TOP = DIGIT_W'(TENS_MAX);

  logic clr_prev, tgl_prev, past_ok;
  logic clr_evt, tgl_evt, all_zero;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      clr_prev <= 1'b0;
      tgl_prev <= 1'b0;
      past_ok  <= 1'b0;
    end else begin
      clr_prev <= clear_i;
      tgl_prev <= run_tgl_i;
      past_ok  <= 1'b1;
    end
  end

  assign clr_evt  = clear_i & ~clr_prev;
  assign tgl_evt  = run_tgl_i & ~tgl_prev;
  assign all_zero = (sec_tens_o == '0) && (sec_ones_o == '0) && (tenths_o == '0);

  p_digit_range_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    tenths_o <= T_TOP && sec_ones_o <= O_TOP && sec_tens_o <= S_TOP);

  p_clear_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_evt |=> all_zero);

  p_clear_wins_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_evt && tgl_evt) |=> all_zero ##1 all_zero);

  p_single_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok && !$past(clr_evt) && !$stable(tenths_o)) |->
      tenths_o == (($past(tenths_o) == T_TOP) ? '0 : $past(tenths_o) + DIGIT_W'(1)));

  p_tenths_carry_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok && !$past(clr_evt) && $past(tenths_o) == T_TOP && tenths_o == '0) |->
      sec_ones_o != $past(sec_ones_o));

  p_ones_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok && !$past(clr_evt) && $past(tenths_o) != T_TOP) |-> $stable(sec_ones_o));

  p_minute_wrap_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (past_ok && !$past(clr_evt) && $past(sec_tens_o) == S_TOP &&
     $past(sec_ones_o) == O_TOP && $past(tenths_o) == T_TOP && tenths_o == '0) |->
      (sec_tens_o == '0 && sec_ones_o == '0));
endmodule

bind sw_bcd_timer sw_bcd_timer_chk #(
  .DIGIT_W   (DIGIT_W),
  .TENTHS_MAX(TENTHS_MAX),
  .ONES_MAX  (ONES_MAX),
  .TENS_MAX  (TENS_MAX)
) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .run_tgl_i (run_tgl_i),
  .clear_i   (clear_i),
  .sec_tens_o(sec_tens_o),
  .sec_ones_o(sec_ones_o),
  .tenths_o  (tenths_o)
);

// File: tb/sw_bcd_timer_bench.sv
module sw_bcd_timer_bench;
  localparam int PERIOD = 10;
  localparam int NVEC   = 21;

  logic clk = 1'b0;
  logic rst, run_tgl, clear;
  logic [3:0] tens, ones, tenths;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sw_bcd_timer u_sw_bcd_timer (
    .clk_i     (clk),
    .rst_i     (rst),
    .run_tgl_i (run_tgl),
    .clear_i   (clear),
    .sec_tens_o(tens),
    .sec_ones_o(ones),
    .tenths_o  (tenths)
  );

  // {run_tgl, clear, expected tens/ones/tenths after the edge}
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 12'h000},  // idle after reset (R1)
    {1'b1, 1'b0, 12'h000},  // run edge: no count yet (R2)
    {1'b1, 1'b0, 12'h001},  // held high, still running (R7)
    {1'b1, 1'b0, 12'h002},
    {1'b0, 1'b0, 12'h003},
    {1'b0, 1'b0, 12'h004},
    {1'b1, 1'b0, 12'h005},  // pause edge, final increment (R6)
    {1'b0, 1'b0, 12'h005},  // held (R6)
    {1'b0, 1'b0, 12'h005},
    {1'b1, 1'b0, 12'h005},  // resume edge (R10)
    {1'b0, 1'b0, 12'h006},  // resumes from held time (R10)
    {1'b0, 1'b0, 12'h007},
    {1'b0, 1'b1, 12'h000},  // clear edge (R8)
    {1'b0, 1'b1, 12'h000},  // clear held, paused (R7, R8)
    {1'b1, 1'b0, 12'h000},  // run edge
    {1'b0, 1'b0, 12'h001},
    {1'b1, 1'b1, 12'h000},  // both edges: clear wins (R9)
    {1'b0, 1'b0, 12'h000},  // still paused (R9)
    {1'b1, 1'b0, 12'h000},  // run edge
    {1'b0, 1'b0, 12'h001},
    {1'b0, 1'b0, 12'h002}
  };

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] bcd_of(int k);
    int w = k % 600;
    return {4'((w / 100) % 6), 4'((w / 10) % 10), 4'(w % 10)};
  endfunction

  function automatic string tag_of(int k);
    if (k % 600 == 0) return "R5";
    if (k % 100 == 0) return "R4";
    if (k % 10 == 0)  return "R3";
    return "R2";
  endfunction

  initial begin
    rst = 1'b1; run_tgl = 1'b0; clear = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", {tens, ones, tenths}, 12'h000);
    rst = 1'b0;

    // Table walk: drive at negedge, judge the result at the next negedge
    for (int i = 0; i < NVEC; i++) begin
      run_tgl = VEC[i][13];
      clear   = VEC[i][12];
      @(negedge clk);
      check("R2/R6/R7/R8/R9/R10 table", {tens, ones, tenths}, VEC[i][11:0]);
    end

    // Full sweep through every carry and the minute wrap
    clear = 1'b1; run_tgl = 1'b0;
    @(negedge clk);
    check("R8 clear before sweep", {tens, ones, tenths}, 12'h000);
    clear = 1'b0; run_tgl = 1'b1;
    @(negedge clk);
    run_tgl = 1'b0;
    for (int k = 1; k <= 610; k++) begin
      @(negedge clk);
      check(tag_of(k), {tens, ones, tenths}, bcd_of(k));
    end

    // Pause mid-count: one last increment, then hold (R6)
    run_tgl = 1'b1;
    @(negedge clk);
    check("R6 pause edge", {tens, ones, tenths}, bcd_of(611));
    run_tgl = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 hold while paused", {tens, ones, tenths}, bcd_of(611));

    // Power-on reset while running (R1)
    run_tgl = 1'b1;
    @(negedge clk);
    run_tgl = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset while running", {tens, ones, tenths}, 12'h000);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 paused after reset", {tens, ones, tenths}, 12'h000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule